// File: doc/BRIEF.md
# Two-Channel Interleaved Converter Mismatch Corrector

This block removes the channel-to-channel errors of a two-way time-interleaved analog-to-digital converter in real time. Each clock carries one frame of P samples (default 8), 12 bits each. Lanes with even indices come from converter channel 0 and lanes with odd indices come from channel 1. For each channel the block subtracts an offset and applies a gain. Channel 1 then goes through a fractional-delay FIR filter with TAPS coefficients (default 5) that corrects its sampling-instant skew. Channel 0 is the timing reference. It is delayed by the FIR group delay, D = (TAPS-1)/2 channel samples, so that both channels stay aligned. The corrected samples leave in the same interleaved lane order after a fixed latency.

The correction values are computed offline by a foreground calibration routine. They are written through a small register port into shadow registers, and a commit strobe makes all of them active together. Every arithmetic step is built from one uniform signed multiply-add unit. TAPS must be odd and at least 3.

Top module: `tiadc_corrector`

## Requirements
- R1: While reset is asserted, valid_o is 0 and data_o is all zeros. The default coefficient set is: both offsets 0, both gains 16384 (1.0 in Q1.14), tap D equal to 16384, and all other taps 0. With these defaults the output equals the input delayed by D channel samples on both channels.
- R2: A frame accepted with valid_i = 1 on a rising edge appears on data_o with valid_o = 1 two rising edges later. When no frame was accepted, valid_o is 0 and data_o keeps its previous value.
- R3: Lane i occupies bits [12i+11:12i] of data_i and of data_o. Even lanes are channel 0 and odd lanes are channel 1, in time order within each channel as the lane index rises.
- R4: Each input sample x of channel c first becomes u = sat(rnd((x - off_c) * gain_c)). The offset is signed 12-bit and the gain is signed Q1.14.
- R5: Output lane 2j is the channel-0 value u0 of the channel-0 sample that lies D samples earlier in the channel-0 stream. This includes samples from earlier accepted frames.
- R6: Output lane 2j+1 is sat(rnd(sum over k of h_k * u1[m-k])), where m is the channel-1 sample index and h_k is tap k (signed Q1.14). Samples from earlier accepted frames are used across frame boundaries.
- R7: rnd(v) adds 2^13 and shifts arithmetically right by 14, which rounds to nearest with ties toward positive infinity. sat clamps the result to [-2048, 2047].
- R8: Register addresses are: 0 = channel-0 offset, 1 = channel-1 offset, 2 = channel-0 gain, 3 = channel-1 gain, and 4+k = tap k. Offsets use the low 12 bits of the 16-bit write data and ignore the upper bits.
- R9: A write only changes the shadow set. A commit pulse copies the whole shadow set into the active set on that edge. Frames accepted on later edges use the new set for every stage, and frames accepted on or before that edge use the old set.
- R10: Cycles with valid_i = 0 do not advance the channel history. The next accepted frame continues from the last accepted one.
- R11: Writes to addresses 4+TAPS and above change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input frame valid |
| data_i | input | P*12 | Input frame, lane i at bits [12i+11:12i] |
| cfg_we_i | input | 1 | Shadow register write enable |
| cfg_addr_i | input | AW | Shadow register address |
| cfg_wdata_i | input | 16 | Shadow register write data |
| cfg_commit_i | input | 1 | Copy the shadow set to the active set |
| valid_o | output | 1 | Output frame valid |
| data_o | output | P*12 | Corrected frame |

## Verification
The assertions check these rules on every cycle: the two-edge valid latency, that data_o holds when no frame was accepted, that the history stays frozen across gaps, that the active set is reloaded only on commit, and that unmapped writes leave the shadow set untouched. The arithmetic itself can only be shown by the bench's scenarios. Its reference model checks the offset and gain, the FIR across frame boundaries, the channel-0 alignment delay, rounding, saturation at both rails, and the exact frame at which a committed set takes effect.

// File: rtl/tiadc_pkg.sv
package tiadc_pkg;
  localparam int FRAC   = 14;
  localparam int Q_ONE  = 1 << FRAC;
  localparam int A_OFF0 = 0;
  localparam int A_OFF1 = 1;
  localparam int A_GN0  = 2;
  localparam int A_GN1  = 3;
  localparam int A_TAP0 = 4;
endpackage

// File: rtl/tiadc_mac.sv
// uniform signed multiply-add: p = a*b + c
module tiadc_mac #(
  parameter int AW  = 13,
  parameter int BW  = 16,
  parameter int CIW = 30,
  parameter int OW  = 30
) (
  input  logic signed [AW-1:0]  a_i,
  input  logic signed [BW-1:0]  b_i,
  input  logic signed [CIW-1:0] c_i,
  output logic signed [OW-1:0]  p_o
);
  assign p_o = OW'(a_i) * OW'(b_i) + OW'(c_i);
endmodule

// File: rtl/tiadc_sat_round.sv
// v_i already carries the rounding constant
module tiadc_sat_round #(
  parameter int IW   = 30,
  parameter int OW   = 12,
  parameter int FRAC = 14
) (
  input  logic signed [IW-1:0] v_i,
  output logic signed [OW-1:0] v_o
);
  localparam logic signed [IW-1:0] MAXV = IW'((2 ** (OW - 1)) - 1);
  localparam logic signed [IW-1:0] MINV = ~MAXV;

  logic signed [IW-1:0] shf;
  assign shf = v_i >>> FRAC;

  always_comb begin
    if (shf > MAXV)      v_o = MAXV[OW-1:0];
    else if (shf < MINV) v_o = MINV[OW-1:0];
    else                 v_o = shf[OW-1:0];
  end
endmodule

// File: rtl/tiadc_coef_bank.sv
module tiadc_coef_bank
  import tiadc_pkg::*;
#(
  parameter int DW   = 12,
  parameter int CW   = 16,
  parameter int TAPS = 5,
  parameter int AW   = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [CW-1:0]        wdata_i,
  input  logic                 commit_i,
  output logic signed [DW-1:0] off_o  [2],
  output logic signed [CW-1:0] gain_o [2],
  output logic signed [CW-1:0] tap_o  [TAPS]
);
  localparam int NREG = A_TAP0 + TAPS;
  localparam int CTR  = (TAPS - 1) / 2;

  function automatic logic [CW-1:0] rst_val(input int idx);
    if (idx == A_GN0 || idx == A_GN1 || idx == A_TAP0 + CTR) return CW'(Q_ONE);
    return '0;
  endfunction

  logic [NREG-1:0][CW-1:0] shd_q, act_q;
  logic                    wr_hit;

  assign wr_hit = we_i && (int'(addr_i) < NREG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) begin
        shd_q[i] <= rst_val(i);
        act_q[i] <= rst_val(i);
      end
    end else begin
      if (commit_i) act_q <= shd_q;
      if (wr_hit)   shd_q[addr_i] <= wdata_i;
    end
  end

  assign off_o[0]  = signed'(act_q[A_OFF0][DW-1:0]);
  assign off_o[1]  = signed'(act_q[A_OFF1][DW-1:0]);
  assign gain_o[0] = signed'(act_q[A_GN0]);
  assign gain_o[1] = signed'(act_q[A_GN1]);

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    assign tap_o[k] = signed'(act_q[A_TAP0+k]);
  end

  AST_ACT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(act_q)); // R9
  AST_ACT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> act_q == $past(shd_q)); // R9
  AST_MAP_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && int'(addr_i) >= NREG) |=> $stable(shd_q)); // R11
endmodule

// File: rtl/tiadc_corrector.sv
module tiadc_corrector
  import tiadc_pkg::*;
#(
  parameter int P    = 8,
  parameter int DW   = 12,
  parameter int CW   = 16,
  parameter int TAPS = 5,
  parameter int AW   = $clog2(tiadc_pkg::A_TAP0 + TAPS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [P*DW-1:0] data_i,
  input  logic            cfg_we_i,
  input  logic [AW-1:0]   cfg_addr_i,
  input  logic [CW-1:0]   cfg_wdata_i,
  input  logic            cfg_commit_i,
  output logic            valid_o,
  output logic [P*DW-1:0] data_o
);
  localparam int H   = P / 2;
  localparam int CTR = (TAPS - 1) / 2;
  localparam int NH1 = TAPS - 1;
  localparam int GW  = DW + 1 + CW + 1;
  localparam int FW  = DW + CW + $clog2(TAPS) + 1;
  localparam logic signed [GW-1:0] RND_G = GW'(2 ** (FRAC - 1));
  localparam logic signed [FW-1:0] RND_F = FW'(2 ** (FRAC - 1));

  logic signed [DW-1:0] off  [2];
  logic signed [CW-1:0] gain [2];
  logic signed [CW-1:0] tap  [TAPS];

  tiadc_coef_bank #(.DW(DW), .CW(CW), .TAPS(TAPS), .AW(AW)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .commit_i(cfg_commit_i),
    .off_o   (off),
    .gain_o  (gain),
    .tap_o   (tap)
  );

  // stage 1: offset and gain on every lane
  logic signed [DW-1:0] u_c [P];

  for (genvar g = 0; g < P; g++) begin : g_lane
    localparam int CH = g % 2;
    logic signed [DW:0]   diff;
    logic signed [GW-1:0] prod;

    assign diff = (DW+1)'(signed'(data_i[g*DW +: DW])) - (DW+1)'(off[CH]);

    tiadc_mac #(.AW(DW+1), .BW(CW), .CIW(GW), .OW(GW)) u_mac (
      .a_i(diff), .b_i(gain[CH]), .c_i(RND_G), .p_o(prod)
    );
    tiadc_sat_round #(.IW(GW), .OW(DW), .FRAC(FRAC)) u_sat (
      .v_i(prod), .v_o(u_c[g])
    );
  end

  logic                      v_s1;
  logic [P-1:0][DW-1:0]      u_q;
  logic [TAPS-1:0][CW-1:0]   hp_q;   // taps travel with their frame

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_s1 <= 1'b0;
      u_q  <= '0;
      hp_q <= '0;
    end else begin
      v_s1 <= valid_i;
      if (valid_i) begin
        for (int g = 0; g < P; g++)    u_q[g]  <= u_c[g];
        for (int k = 0; k < TAPS; k++) hp_q[k] <= tap[k];
      end
    end
  end

  // stage 2: skew FIR on channel 1, alignment delay on channel 0
  logic [NH1-1:0][DW-1:0] h1_q;
  logic [CTR-1:0][DW-1:0] h0_q;
  logic signed [DW-1:0]   e1 [NH1+H];
  logic signed [DW-1:0]   e0 [CTR+H];
  logic signed [DW-1:0]   y1 [H];

  for (genvar i = 0; i < NH1; i++) begin : g_e1h
    assign e1[i] = signed'(h1_q[i]);
  end
  for (genvar i = 0; i < CTR; i++) begin : g_e0h
    assign e0[i] = signed'(h0_q[i]);
  end
  for (genvar j = 0; j < H; j++) begin : g_ecur
    assign e1[NH1+j] = signed'(u_q[2*j+1]);
    assign e0[CTR+j] = signed'(u_q[2*j]);
  end

  for (genvar j = 0; j < H; j++) begin : g_fir
    logic signed [FW-1:0] acc [TAPS+1];
    assign acc[0] = RND_F;
    for (genvar k = 0; k < TAPS; k++) begin : g_tap
      tiadc_mac #(.AW(DW), .BW(CW), .CIW(FW), .OW(FW)) u_mac (
        .a_i(e1[NH1+j-k]), .b_i(signed'(hp_q[k])), .c_i(acc[k]), .p_o(acc[k+1])
      );
    end
    tiadc_sat_round #(.IW(FW), .OW(DW), .FRAC(FRAC)) u_sat (
      .v_i(acc[TAPS]), .v_o(y1[j])
    );
  end

  logic [P-1:0][DW-1:0] out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      out_q   <= '0;
      h1_q    <= '0;
      h0_q    <= '0;
    end else begin
      valid_o <= v_s1;
      if (v_s1) begin
        for (int j = 0; j < H; j++) begin
          out_q[2*j]   <= e0[j];
          out_q[2*j+1] <= y1[j];
        end
        for (int i = 0; i < NH1; i++) h1_q[i] <= e1[H+i];
        for (int i = 0; i < CTR; i++) h0_q[i] <= e0[H+i];
      end
    end
  end

  assign data_o = out_q;

  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ##2 valid_o); // R2
  AST_VALID_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> ##2 !valid_o); // R2
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> ##2 $stable(data_o)); // R2
  AST_HIST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !v_s1 |=> ($stable(h1_q) && $stable(h0_q))); // R10
endmodule

// File: tb/sim_tiadc_corrector.sv
`timescale 1ns/1ps
module sim_tiadc_corrector;
  localparam int P = 8, DW = 12, CW = 16, TAPS = 5, AW = 4, NREG = 9;

  logic clk = 1'b0, rst_ni = 1'b0, valid_i = 1'b0;
  logic [P*DW-1:0] data_i = '0;
  logic cfg_we_i = 1'b0, cfg_commit_i = 1'b0;
  logic [AW-1:0] cfg_addr_i = '0;
  logic [CW-1:0] cfg_wdata_i = '0;
  logic valid_o;
  logic [P*DW-1:0] data_o;

  always #10 clk = ~clk;

  tiadc_corrector #(.P(P), .DW(DW), .CW(CW), .TAPS(TAPS), .AW(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
    .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
    .cfg_commit_i(cfg_commit_i), .valid_o(valid_o), .data_o(data_o)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string tag = "R1";
  int sh[NREG], act[NREG];
  int h0[2], h1[4];
  int s1_v = 0, out_v = 0;
  int s1_d[P], out_d[P], xin[P];

  function automatic int sx16(input int w);
    return ((w & 16'hffff) ^ 32768) - 32768;
  endfunction
  function automatic int sx12(input int w);
    return ((w & 12'hfff) ^ 2048) - 2048;
  endfunction
  function automatic int sat_rnd(input int v);  // R7
    int r;
    r = (v + 8192) >>> 14;
    if (r > 2047) r = 2047;
    if (r < -2048) r = -2048;
    return r;
  endfunction

  task automatic compare();
    int got;
    n_cmp++;
    if (valid_o !== out_v[0]) begin
      n_bad++;
      $display("FAIL %s valid_o got %0b exp %0d", tag, valid_o, out_v);
    end
    for (int g = 0; g < P; g++) begin
      got = $signed(data_o[g*DW +: DW]);
      if (got != out_d[g]) begin
        n_bad++;
        $display("FAIL %s lane %0d got %0d exp %0d", tag, g, got, out_d[g]);
      end
    end
  endtask

  task automatic model(input bit v, input bit we, input int addr, input int wd, input bit cm);
    int u[P], y[P], e0[6], e1[8], s;
    if (v) begin
      for (int g = 0; g < P; g++)
        u[g] = sat_rnd((xin[g] - sx12(act[g%2])) * sx16(act[2+g%2]));
      e0[0] = h0[0]; e0[1] = h0[1];
      for (int i = 0; i < 4; i++) e1[i] = h1[i];
      for (int j = 0; j < 4; j++) begin
        e0[2+j] = u[2*j];
        e1[4+j] = u[2*j+1];
      end
      for (int j = 0; j < 4; j++) begin
        y[2*j] = e0[j];
        s = 0;
        for (int k = 0; k < TAPS; k++) s += sx16(act[4+k]) * e1[4+j-k];
        y[2*j+1] = sat_rnd(s);
      end
      h0[0] = e0[4]; h0[1] = e0[5];
      for (int i = 0; i < 4; i++) h1[i] = e1[4+i];
    end
    out_v = s1_v;
    if (s1_v != 0) out_d = s1_d;
    s1_v = v;
    if (v) s1_d = y;
    if (cm) act = sh;
    if (we && addr < NREG) sh[addr] = wd & 16'hffff;
  endtask

  task automatic cycle(input bit v, input bit we = 0, input int addr = 0,
                       input int wd = 0, input bit cm = 0);
    @(negedge clk);
    compare();
    valid_i = v;
    for (int g = 0; g < P; g++) data_i[g*DW +: DW] = xin[g][DW-1:0];
    cfg_we_i = we; cfg_addr_i = addr[AW-1:0]; cfg_wdata_i = wd[CW-1:0];
    cfg_commit_i = cm;
    model(v, we, addr, wd, cm);
  endtask

  task automatic rnd_frame();
    for (int g = 0; g < P; g++) xin[g] = int'($urandom_range(4095)) - 2048;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NREG; i++) sh[i] = (i == 2 || i == 3 || i == 6) ? 16384 : 0;
    act = sh;
    h0 = '{0, 0}; h1 = '{0, 0, 0, 0};
    for (int g = 0; g < P; g++) begin s1_d[g] = 0; out_d[g] = 0; xin[g] = 0; end
    // R1: reset state
    tag = "R1";
    repeat (3) begin @(negedge clk); compare(); end
    @(negedge clk); rst_ni = 1'b1;

    // R1 R3 R5: defaults give a pure alignment delay on both channels
    tag = "R1 R3 R5";
    for (int f = 0; f < 8; f++) begin
      for (int g = 0; g < P; g++) xin[g] = f * 100 + g * 11 - 400;
      cycle(1);
    end
    // R2 R10: gaps keep outputs and history
    tag = "R2 R10";
    for (int f = 0; f < 12; f++) begin
      rnd_frame();
      cycle(f % 3 == 0);
    end
    // R9 R8: shadow writes alone change nothing
    tag = "R9 R8";
    begin
      int adr[9] = '{0, 1, 2, 3, 4, 5, 6, 7, 8};
      int val[9] = '{16'hF025, -21, 15000, 17500, -600, 2400, 13500, 1500, -400};
      for (int i = 0; i < 9; i++) begin
        rnd_frame();
        cycle(1, 1, adr[i], val[i]);
      end
    end
    // R9: commit edge splits old/new frames
    tag = "R9";
    rnd_frame(); cycle(1, 0, 0, 0, 1);
    // R3 R4 R6 R8: new offsets, gains and FIR across frames
    tag = "R3 R4 R6 R8";
    for (int f = 0; f < 20; f++) begin rnd_frame(); cycle(1); end
    // R11: unmapped writes then commit
    tag = "R11";
    rnd_frame(); cycle(1, 1, 9, 16'h7fff);
    rnd_frame(); cycle(1, 1, 15, 16'h1234);
    rnd_frame(); cycle(0, 0, 0, 0, 1);
    for (int f = 0; f < 6; f++) begin rnd_frame(); cycle(1); end
    // R7: saturation both rails
    tag = "R7";
    cycle(0, 1, 2, 32767); cycle(0, 1, 3, 32767);
    cycle(0, 1, 0, 0); cycle(0, 1, 1, 0);
    cycle(0, 1, 4, 16384); cycle(0, 1, 5, 16384);
    cycle(0, 1, 7, 16384); cycle(0, 1, 8, 16384); cycle(0, 0, 0, 0, 1);
    for (int f = 0; f < 10; f++) begin
      for (int g = 0; g < P; g++) xin[g] = (f % 2 == 0) ? 2047 - g : -2048 + g;
      if (f >= 6) rnd_frame();
      cycle(1);
    end
    // R4 R6 R10: random mix with random valid and mid-stream commit
    tag = "R4 R6 R10";
    cycle(0, 1, 2, 14000); cycle(0, 1, 5, -1200); cycle(0, 1, 1, 16'h0fa0);
    for (int f = 0; f < 60; f++) begin
      rnd_frame();
      cycle($urandom_range(3) != 0, 0, 0, 0, f == 30);
    end
    for (int f = 0; f < 4; f++) cycle(0);
    finish_run();
  end
endmodule